// File: doc/BRIEF.md
# Row-Programmed Non-Volatile Word Memory Controller

This block models a word-organised non-volatile program store, with the control logic around it. The store cannot be changed one word at a time. A host first fills a row-wide buffer of word latches through a byte-wide load port. Each 14-bit word needs two byte loads. The host then issues an erase or a write command that names a row. An erase drives every bit of the row to one. A write can only clear bits: each stored word becomes the AND of its old value and the latched value.

While a command runs, the block holds a busy flag for a fixed number of cycles. It ignores latch loads and further commands during that time. When the command completes, it raises a one-cycle completion pulse. The block keeps a saturating write-cycle counter for each row. It flags a row that has exceeded its endurance limit. A registered read port returns any stored word, together with the counter and wear flag of that word's row.

Top module: `fw_row_flash`

## Requirements
- R1: After reset, busy and done are low, every stored word reads 0x3FFF, and every row's write-cycle count reads 0 with the wear flag low.
- R2: A load with ld_hi=0 places ld_byte into bits [7:0] of the latch selected by ld_idx. A load with ld_hi=1 places ld_byte[5:0] into bits [13:8] of that latch and discards ld_byte[7:6].
- R3: A command with cmd_op=0 (erase) sets all 32 words of the row given by cmd_addr[7:5] to 0x3FFF. It ignores cmd_addr[4:0] and leaves other rows unchanged.
- R4: A command with cmd_op=1 (write) replaces each word w of the addressed row with old[w] AND latch[w], so no bit can go from 0 to 1.
- R5: Every latch returns to 0x3FFF when a write completes, so a word whose latch was not loaded before the next write keeps its stored value.
- R6: An accepted command raises busy in the next cycle and holds it for exactly BUSY_CYCLES cycles. done is high for exactly one cycle, the first cycle after busy falls.
- R7: While busy is high, latch loads and commands have no effect.
- R8: rd_data, rd_cycles and rd_worn show the word at rd_addr (row rd_addr[7:5], word rd_addr[4:0]) and its row's counter one cycle after rd_addr is applied. These outputs hold their value while busy is high.
- R9: Each completed write adds one to its row's counter, and erases leave the counter unchanged. The counter saturates at ENDURANCE+1, and rd_worn is high when the count exceeds ENDURANCE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_en | input | 1 | Load one byte into a word latch |
| ld_hi | input | 1 | 0: low byte, 1: upper 6 bits |
| ld_idx | input | 5 | Latch (word within row) index |
| ld_byte | input | 8 | Byte to load |
| cmd_valid | input | 1 | Issue a row command |
| cmd_op | input | 1 | 0 erase, 1 write |
| cmd_addr | input | 8 | Word address; only the row part is used |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_addr | input | 8 | Read word address |
| rd_data | output | 14 | Stored word |
| rd_cycles | output | 14 | Write-cycle count of the read row |
| rd_worn | output | 1 | Read row exceeded its endurance |

## Verification
The state that is hardest to reach from the ports is a row whose counter is saturated. A second hard case is a row written twice without an erase in between, because only then does the AND behaviour show up against data that is not all ones. The bench sets the endurance limit low and issues repeated writes to one row until the counter passes the limit and saturates. Its random rounds deliberately skip erases, so that new latch data lands on partly cleared words. During busy windows the bench also drives stray loads and commands. A later write with untouched latches then shows whether any of them leaked through.

// File: rtl/fw_pkg.sv
package fw_pkg;
    typedef enum logic {
        OP_ERASE = 1'b0,
        OP_WRITE = 1'b1
    } fw_op_e;
endpackage

// File: rtl/fw_seq.sv
module fw_seq
    import fw_pkg::*;
#(
    parameter int BUSY_CYCLES = 4,
    parameter int ROW_W       = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  fw_op_e           cmd_op,
    input  logic [ROW_W-1:0] cmd_row,
    output logic             busy,
    output logic             done,
    output logic             commit,
    output fw_op_e           commit_op,
    output logic [ROW_W-1:0] commit_row
);
    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [CNT_W-1:0] cnt;
        fw_op_e           op;
        logic [ROW_W-1:0] row;
    } seq_t;

    seq_t s_d, s_q;
    logic last_q;

    assign last_q = s_q.busy && (s_q.cnt == '0);

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (s_q.busy) begin
            if (last_q) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt - CNT_W'(1);
            end
        end else if (cmd_valid) begin
            s_d.busy = 1'b1;
            s_d.cnt  = CNT_W'(BUSY_CYCLES - 1);
            s_d.op   = cmd_op;
            s_d.row  = cmd_row;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.busy <= 1'b0;
            s_q.done <= 1'b0;
            s_q.cnt  <= '0;
            s_q.op   <= OP_ERASE;
            s_q.row  <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy       = s_q.busy;
    assign done       = s_q.done;
    assign commit     = last_q;
    assign commit_op  = s_q.op;
    assign commit_row = s_q.row;

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |=> !s_q.done);
    // R6
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.busy) |-> s_q.done);
    // R7
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && s_q.cnt != '0) |=> (s_q.busy && $stable(s_q.row) && $stable(s_q.op)));
endmodule

// File: rtl/fw_latch.sv
module fw_latch #(
    parameter int WORD_W    = 14,
    parameter int ROW_WORDS = 32
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 ld_en,
    input  logic                                 ld_hi,
    input  logic [$clog2(ROW_WORDS)-1:0]         ld_idx,
    input  logic [7:0]                           ld_byte,
    input  logic                                 clr,
    output logic [ROW_WORDS-1:0][WORD_W-1:0]     lat
);
    localparam int HI_W = WORD_W - 8;

    typedef struct packed {
        logic [ROW_WORDS-1:0][WORD_W-1:0] lat;
    } lat_t;

    lat_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr) begin
            s_d.lat = '1;
        end else if (ld_en) begin
            if (ld_hi) begin
                s_d.lat[ld_idx][WORD_W-1:8] = ld_byte[HI_W-1:0];
            end else begin
                s_d.lat[ld_idx][7:0] = ld_byte;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q.lat <= '1;
        else        s_q <= s_d;
    end

    assign lat = s_q.lat;

    // R5
    lat_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (&s_q.lat));
endmodule

// File: rtl/fw_array.sv
module fw_array
    import fw_pkg::*;
#(
    parameter int WORD_W    = 14,
    parameter int ROW_WORDS = 32,
    parameter int ROWS      = 8,
    parameter int ENDURANCE = 10000,
    parameter int CYC_W     = 14
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic                                          commit,
    input  fw_op_e                                        op,
    input  logic [$clog2(ROWS)-1:0]                       row,
    input  logic [ROW_WORDS-1:0][WORD_W-1:0]              lat,
    input  logic                                          rd_en,
    input  logic [$clog2(ROWS)+$clog2(ROW_WORDS)-1:0]     rd_addr,
    output logic [WORD_W-1:0]                             rd_data,
    output logic [CYC_W-1:0]                              rd_cycles,
    output logic                                          rd_worn
);
    localparam int IDX_W = $clog2(ROW_WORDS);
    localparam int ROW_W = $clog2(ROWS);
    localparam logic [CYC_W-1:0] CYC_TOP   = CYC_W'(ENDURANCE + 1);
    localparam logic [CYC_W-1:0] CYC_LIMIT = CYC_W'(ENDURANCE);

    typedef struct packed {
        logic [ROWS-1:0][ROW_WORDS-1:0][WORD_W-1:0] mem;
        logic [ROWS-1:0][CYC_W-1:0]                 cyc;
        logic [WORD_W-1:0]                          rd_data;
        logic [CYC_W-1:0]                           rd_cyc;
    } arr_t;

    arr_t s_d, s_q;
    logic [ROW_W-1:0] rd_row;
    logic [IDX_W-1:0] rd_idx;

    assign rd_row = rd_addr[ROW_W+IDX_W-1:IDX_W];
    assign rd_idx = rd_addr[IDX_W-1:0];

    always_comb begin
        s_d = s_q;
        if (rd_en) begin
            s_d.rd_data = s_q.mem[rd_row][rd_idx];
            s_d.rd_cyc  = s_q.cyc[rd_row];
        end
        if (commit) begin
            for (int w = 0; w < ROW_WORDS; w++) begin
                if (op == OP_WRITE) s_d.mem[row][w] = s_q.mem[row][w] & lat[w];
                else                s_d.mem[row][w] = '1;
            end
            if (op == OP_WRITE && s_q.cyc[row] < CYC_TOP) begin
                s_d.cyc[row] = s_q.cyc[row] + CYC_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.mem     <= '1;
            s_q.cyc     <= '0;
            s_q.rd_data <= '1;
            s_q.rd_cyc  <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_data   = s_q.rd_data;
    assign rd_cycles = s_q.rd_cyc;
    assign rd_worn   = s_q.rd_cyc > CYC_LIMIT;

    // R3
    erase_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && op == OP_ERASE) |=> (&s_q.mem[$past(row)]));

    // R8
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> ($stable(s_q.rd_data) && $stable(s_q.rd_cyc)));

    for (genvar r = 0; r < ROWS; r++) begin : g_cyc
        // R9
        cyc_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
            s_q.cyc[r] >= $past(s_q.cyc[r]));
        // R9
        cyc_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
            s_q.cyc[r] <= CYC_TOP);
    end
endmodule

// File: rtl/fw_row_flash.sv
module fw_row_flash
    import fw_pkg::*;
#(
    parameter int WORD_W      = 14,
    parameter int ROW_WORDS   = 32,
    parameter int ROWS        = 8,
    parameter int BUSY_CYCLES = 4,
    parameter int ENDURANCE   = 10000,
    localparam int IDX_W      = $clog2(ROW_WORDS),
    localparam int ROW_W      = $clog2(ROWS),
    localparam int ADDR_W     = ROW_W + IDX_W,
    localparam int CYC_W      = $clog2(ENDURANCE + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic              ld_hi,
    input  logic [IDX_W-1:0]  ld_idx,
    input  logic [7:0]        ld_byte,
    input  logic              cmd_valid,
    input  logic              cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    output logic              busy,
    output logic              done,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data,
    output logic [CYC_W-1:0]  rd_cycles,
    output logic              rd_worn
);
    logic                             commit;
    fw_op_e                           commit_op;
    logic [ROW_W-1:0]                 commit_row;
    logic [ROW_WORDS-1:0][WORD_W-1:0] lat;
    logic                             ld_ok;
    logic                             lat_clr;
    logic                             cmd_idx_unused;

    assign cmd_idx_unused = ^cmd_addr[IDX_W-1:0];
    assign ld_ok          = ld_en && !busy;
    assign lat_clr        = commit && (commit_op == OP_WRITE);

    fw_seq #(.BUSY_CYCLES(BUSY_CYCLES), .ROW_W(ROW_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_op     (fw_op_e'(cmd_op)),
        .cmd_row    (cmd_addr[ADDR_W-1:IDX_W]),
        .busy       (busy),
        .done       (done),
        .commit     (commit),
        .commit_op  (commit_op),
        .commit_row (commit_row)
    );

    fw_latch #(.WORD_W(WORD_W), .ROW_WORDS(ROW_WORDS)) u_lat (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_en   (ld_ok),
        .ld_hi   (ld_hi),
        .ld_idx  (ld_idx),
        .ld_byte (ld_byte),
        .clr     (lat_clr),
        .lat     (lat)
    );

    fw_array #(
        .WORD_W(WORD_W), .ROW_WORDS(ROW_WORDS), .ROWS(ROWS),
        .ENDURANCE(ENDURANCE), .CYC_W(CYC_W)
    ) u_arr (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit    (commit),
        .op        (commit_op),
        .row       (commit_row),
        .lat       (lat),
        .rd_en     (!busy),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .rd_cycles (rd_cycles),
        .rd_worn   (rd_worn)
    );
endmodule

// File: tb/sim_fw_row_flash.sv
module sim_fw_row_flash;
    localparam int ENDUR = 12;
    localparam int BUSYC = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_en = 1'b0, ld_hi = 1'b0;
    logic [4:0]  ld_idx = '0;
    logic [7:0]  ld_byte = '0;
    logic        cmd_valid = 1'b0, cmd_op = 1'b0;
    logic [7:0]  cmd_addr = '0;
    logic        busy, done;
    logic [7:0]  rd_addr = '0;
    logic [13:0] rd_data;
    logic [3:0]  rd_cycles;
    logic        rd_worn;

    int checks = 0;
    int errors = 0;
    logic [13:0] m_mem [8][32];
    logic [13:0] m_lat [32];
    int          m_cyc [8];

    always #5 clk = ~clk;

    fw_row_flash #(.BUSY_CYCLES(BUSYC), .ENDURANCE(ENDUR)) u0 (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_hi(ld_hi), .ld_idx(ld_idx),
        .ld_byte(ld_byte), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .busy(busy), .done(done), .rd_addr(rd_addr), .rd_data(rd_data),
        .rd_cycles(rd_cycles), .rd_worn(rd_worn)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic load_word(input int idx, input logic [13:0] w);
        ld_en = 1'b1; ld_hi = 1'b0; ld_idx = 5'(idx); ld_byte = w[7:0];
        tick();
        ld_hi = 1'b1; ld_byte = {2'($urandom), w[13:8]};
        tick();
        ld_en = 1'b0;
        m_lat[idx] = w;
    endtask

    task automatic do_cmd(input logic op, input int row, input bit junk);
        logic [13:0] hold;
        int n;
        hold = m_mem[rd_addr[7:5]][rd_addr[4:0]];
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = {3'(row), 5'($urandom)};
        tick();
        cmd_valid = 1'b0;
        rd_addr = 8'($urandom);
        n = 0;
        while (busy && n < 50) begin
            n++;
            chk("R8 hold", rd_data, hold);
            if (junk) begin
                ld_en = 1'b1; ld_hi = 1'($urandom); ld_idx = 5'($urandom);
                ld_byte = 8'h00;
                cmd_valid = 1'b1; cmd_op = 1'b0; cmd_addr = 8'($urandom);
            end
            tick();
        end
        ld_en = 1'b0; cmd_valid = 1'b0;
        chk("R6 busy len", n, BUSYC);
        chk("R6 done", done, 1);
        tick();
        chk("R6 done once", done, 0);
        for (int w = 0; w < 32; w++) begin
            if (op) m_mem[row][w] = m_mem[row][w] & m_lat[w];
            else    m_mem[row][w] = 14'h3FFF;
        end
        if (op) begin
            for (int w = 0; w < 32; w++) m_lat[w] = 14'h3FFF;
            if (m_cyc[row] < ENDUR + 1) m_cyc[row]++;
        end
    endtask

    task automatic rd_chk(input string req, input int row, input int idx);
        rd_addr = {3'(row), 5'(idx)};
        tick();
        chk(req, rd_data, m_mem[row][idx]);
    endtask

    task automatic row_chk(input string req, input int row);
        for (int w = 0; w < 32; w++) rd_chk(req, row, w);
    endtask

    task automatic cyc_chk(input int row);
        rd_addr = {3'(row), 5'd0};
        tick();
        chk("R9 count", rd_cycles, m_cyc[row]);
        chk("R9 worn", rd_worn, (m_cyc[row] > ENDUR) ? 1 : 0);
    endtask

    task automatic finish_up();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog act=0 exp=1");
        finish_up();
    end

    initial begin
        void'($urandom(32'd17));
        for (int r = 0; r < 8; r++) begin
            m_cyc[r] = 0;
            for (int w = 0; w < 32; w++) m_mem[r][w] = 14'h3FFF;
        end
        for (int w = 0; w < 32; w++) m_lat[w] = 14'h3FFF;
        tick(); tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        rd_chk("R1 word", 3, 7);
        rd_chk("R1 word", 7, 31);
        cyc_chk(2);

        // R2 byte placement, R4 write into erased row, upper bits discarded
        load_word(0, 14'h0000);
        load_word(5, 14'h2A5C);
        load_word(31, 14'h1234);
        do_cmd(1'b1, 1, 1'b0);
        row_chk("R2 R4 write", 1);
        row_chk("R3 other row", 0);

        // R4 AND on second write without erase; R5 unloaded words kept
        load_word(5, 14'h3F0F);
        do_cmd(1'b1, 1, 1'b0);
        rd_chk("R4 and", 1, 5);
        rd_chk("R5 unloaded", 1, 31);

        // R3 erase restores ones
        do_cmd(1'b0, 1, 1'b0);
        row_chk("R3 erase", 1);

        // R7 stray loads and commands during busy
        load_word(3, 14'h0F0F);
        do_cmd(1'b1, 2, 1'b1);
        do_cmd(1'b1, 2, 1'b0);
        row_chk("R7 ignored", 2);
        row_chk("R7 no cmd", 6);

        // random rounds
        for (int k = 0; k < 8; k++) begin
            int row;
            row = int'($urandom % 8);
            if (($urandom % 3) == 0) do_cmd(1'b0, row, 1'b0);
            for (int j = 0; j < 6; j++) load_word(int'($urandom % 32), 14'($urandom));
            do_cmd(1'b1, row, ($urandom % 2) == 1);
            row_chk("R4 random", row);
            cyc_chk(row);
        end

        // R9 endurance saturation on row 5, erase not counted
        do_cmd(1'b0, 5, 1'b0);
        cyc_chk(5);
        for (int k = 0; k < ENDUR + 3; k++) begin
            do_cmd(1'b1, 5, 1'b0);
            cyc_chk(5);
        end

        for (int r = 0; r < 8; r++) row_chk("R3 R4 final", r);
        finish_up();
    end
endmodule